// File: doc/BRIEF.md
# Arithmetic Unit with Bit-Count and Random Operations

This block is the combinational execution unit of a small 32-bit RISC core. It takes a 4-bit operation select, operand A and a second operand. The second operand is either a register value or a 16-bit immediate from the instruction, chosen by a format select. The unit returns a 32-bit result and a carry flag in the same cycle. Register reads, writeback and flag storage belong to the surrounding pipeline.

The unit supports add, subtract, low-word multiply, logical shifts and rotates. It also has three bit-count operations on operand A: set bits, clear bits, and transitions between neighbouring bits. Its one clocked element is a 32-bit linear feedback shift register. The current state of that register is the result of the random operation. The register moves one step at every clock edge on which that operation is selected.

Top module: `alu_core`

## Requirements
- R1: With op = 0 (add), result is the low 32 bits of A + B and carry is bit 32 of the full sum.
- R2: With op = 1 (subtract), result is A - B modulo 2^32 and carry is 1 exactly when A < B as unsigned numbers (borrow).
- R3: With op = 2 (multiply), result is the low 32 bits of the unsigned product A * B.
- R4: With op = 3 (shift right) and op = 4 (shift left), A is shifted logically with zero fill. The shift amount is B[4:0], and bits 31..5 of B are ignored.
- R5: With op = 5 (rotate right) and op = 6 (rotate left), A is rotated by B[4:0] positions.
- R6: With op = 7, result is the number of 1 bits in A, in the range 0 to 32.
- R7: With op = 8, result is the number of 0 bits in A, in the range 0 to 32. This is always 32 minus the count of R6.
- R8: With op = 9, result is the number of positions i in 0..30 where A[i] differs from A[i+1], in the range 0 to 31.
- R9: When imm_sel = 1, operand B is {16'h0000, imm}. When imm_sel = 0, operand B is b_reg.
- R10: With op = 10 (random), result is the generator state. After reset the state is the seed 32'h5EED0001. At each rising clock edge with op = 10 the state becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}. At any other edge it holds. The state is never zero.
- R11: carry is 0 for every op other than 0 and 1.
- R12: Op codes 11 to 15 are reserved and give result 0 and carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the random generator |
| rst_n | input | 1 | Asynchronous active-low reset, loads the seed |
| op | input | 4 | Operation select |
| imm_sel | input | 1 | 1 selects the zero-extended immediate as operand B |
| a | input | 32 | Operand A |
| b_reg | input | 32 | Register form of operand B |
| imm | input | 16 | Immediate form of operand B |
| result | output | 32 | Operation result |
| carry | output | 1 | Add carry or subtract borrow |

## Verification
The generator state can be seen only while op = 10 is applied, and every such cycle also changes it. A step that is missed or taken twice therefore shows up only as a mismatch in a later sample. The bench keeps its own copy of the register. It inserts runs of non-random operations between random ones, so a hold or a wrong step in any gap shows up on the next random read. Shift and rotate amounts come with random upper bits in B, and the boundary amounts 0 and 31 are driven directly. Bit-count operands include all-zero, all-one and alternating patterns, which reach the ends of each count's range.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW = 32;
  localparam int IW = 16;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_SHR  = 4'd3,
    OP_SHL  = 4'd4,
    OP_ROR  = 4'd5,
    OP_ROL  = 4'd6,
    OP_ONES = 4'd7,
    OP_ZERO = 4'd8,
    OP_CHG  = 4'd9,
    OP_RAND = 4'd10
  } alu_op_e;

  function automatic logic [DW-1:0] mul_low(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW-1:0] p;
    p = x * y;
    return p;
  endfunction

  function automatic logic [DW:0] add_wide(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [DW:0] sub_wide(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction
endpackage

// File: rtl/alu_bitcount.sv
module alu_bitcount #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/alu_shiftrot.sv
module alu_shiftrot #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          rotate,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:SW];
  assign stage[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] moved;
    always_comb begin
      if (left) begin
        moved = {stage[s][W-K-1:0], (rotate ? stage[s][W-1:W-K] : {K{1'b0}})};
      end else begin
        moved = {(rotate ? stage[s][K-1:0] : {K{1'b0}}), stage[s][W-1:K]};
      end
    end
    assign stage[s+1] = amt[s] ? moved : stage[s];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/alu_lfsr.sv
module alu_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'h5EED_0001,
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (step) begin
      state <= {state[W-2:0], fb};
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter logic [DW-1:0] SEED = 32'h5EED_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic          imm_sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b_reg,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] result,
  output logic          carry
);
  localparam int CW = $clog2(DW + 1);
  localparam int SW = $clog2(DW);

  alu_op_e       op_e;
  logic [DW-1:0] b_op;
  logic [DW:0]   add_full;
  logic [DW:0]   sub_full;
  logic [CW-1:0] ones_cnt;
  logic [CW-1:0] zeros_cnt;
  logic [CW-1:0] chg_cnt;
  logic [DW-1:0] edge_vec;
  logic [DW-1:0] sr_out;
  logic          sr_left;
  logic          sr_rot;
  logic          rand_step;
  logic [DW-1:0] lfsr_q;

  assign op_e = alu_op_e'(op);
  assign b_op = imm_sel ? {{(DW-IW){1'b0}}, imm} : b_reg;

  assign add_full = add_wide(a, b_op);
  assign sub_full = sub_wide(a, b_op);

  assign edge_vec = {1'b0, a[DW-1:1] ^ a[DW-2:0]};

  alu_bitcount #(.W(DW)) u_ones (.vec(a),        .count(ones_cnt));
  alu_bitcount #(.W(DW)) u_zero (.vec(~a),       .count(zeros_cnt));
  alu_bitcount #(.W(DW)) u_chg  (.vec(edge_vec), .count(chg_cnt));

  assign sr_left = (op_e == OP_SHL) || (op_e == OP_ROL);
  assign sr_rot  = (op_e == OP_ROR) || (op_e == OP_ROL);

  alu_shiftrot #(.W(DW)) u_sr (
    .din(a), .amt(b_op[SW-1:0]), .left(sr_left), .rotate(sr_rot), .dout(sr_out)
  );

  assign rand_step = (op_e == OP_RAND);

  alu_lfsr #(.W(DW), .SEED(SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .step(rand_step), .state(lfsr_q)
  );

  always_comb begin
    result = '0;
    carry  = 1'b0;
    case (op_e)
      OP_ADD:  begin result = add_full[DW-1:0]; carry = add_full[DW]; end
      OP_SUB:  begin result = sub_full[DW-1:0]; carry = sub_full[DW]; end
      OP_MUL:  result = mul_low(a, b_op);
      OP_SHR, OP_SHL, OP_ROR, OP_ROL: result = sr_out;
      OP_ONES: result = {{(DW-CW){1'b0}}, ones_cnt};
      OP_ZERO: result = {{(DW-CW){1'b0}}, zeros_cnt};
      OP_CHG:  result = {{(DW-CW){1'b0}}, chg_cnt};
      OP_RAND: result = lfsr_q;
      default: begin result = '0; carry = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op,
  input logic        imm_sel,
  input logic [15:0] imm,
  input logic [31:0] b_op,
  input logic [31:0] result,
  input logic        carry,
  input logic [5:0]  ones_cnt,
  input logic [5:0]  zeros_cnt,
  input logic [31:0] lfsr_q
);
  p_carry_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd1) |-> (carry == 1'b0));

  p_count_total_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (7'(ones_cnt) + 7'(zeros_cnt)) == 7'd32);

  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7 || op == 4'd8 || op == 4'd9) |-> (result <= 32'd32));

  p_imm_zext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    imm_sel |-> (b_op == {16'h0000, imm}));

  p_rand_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 4'd10) |=> $stable(lfsr_q));

  p_rand_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd10) |=> (lfsr_q != $past(lfsr_q)));

  p_rand_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 32'd0);

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd10) |-> (result == 32'd0 && carry == 1'b0));
endmodule

bind alu_core alu_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .imm_sel(imm_sel), .imm(imm),
  .b_op(b_op), .result(result), .carry(carry),
  .ones_cnt(ones_cnt), .zeros_cnt(zeros_cnt), .lfsr_q(lfsr_q)
);

// File: tb/alu_core_test.sv
module alu_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        imm_sel = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b_reg = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        carry;

  int checks = 0;
  int fails = 0;
  logic [31:0] rng_model;

  always #4 clk = ~clk;

  alu_core uut (
    .clk(clk), .rst_n(rst_n), .op(op), .imm_sel(imm_sel), .a(a),
    .b_reg(b_reg), .imm(imm), .result(result), .carry(carry)
  );

  function automatic int bits_set(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic int flips(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 31; i++) if (v[i] != v[i+1]) n++;
    return n;
  endfunction

  function automatic logic [31:0] rng_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [32:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [31:0] rs);
    logic [63:0] pr;
    logic [63:0] dbl;
    int k;
    k = int'(y[4:0]);
    dbl = {x, x};
    case (o)
      4'd0: return {1'b0, x} + {1'b0, y};
      4'd1: return {(x < y), x - y};
      4'd2: begin pr = {32'd0, x} * {32'd0, y}; return {1'b0, pr[31:0]}; end
      4'd3: return {1'b0, x >> k};
      4'd4: return {1'b0, x << k};
      4'd5: begin dbl = dbl >> k; return {1'b0, dbl[31:0]}; end
      4'd6: begin dbl = dbl << k; return {1'b0, dbl[63:32]}; end
      4'd7: return 33'(bits_set(x));
      4'd8: return 33'(32 - bits_set(x));
      4'd9: return 33'(flips(x));
      4'd10: return {1'b0, rs};
      default: return 33'd0;
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic isel, input logic [31:0] x,
                     input logic [31:0] y, input logic [15:0] im, input string tag);
    logic [32:0] exp;
    logic [31:0] bo;
    @(negedge clk);
    op = o; imm_sel = isel; a = x; b_reg = y; imm = im;
    bo = isel ? {16'd0, im} : y;
    #1;
    exp = model(o, x, bo, rng_model);
    checks++;
    if ({carry, result} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d: got carry=%0b result=%h, expected carry=%0b result=%h",
               tag, o, carry, result, exp[32], exp[31:0]);
    end
    if (o == 4'd10) rng_model = rng_next(rng_model);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    rng_model = 32'h5EED_0001;
    repeat (3) @(posedge clk);
    // R10 reset state visible while held in reset
    @(negedge clk);
    op = 4'd10;
    #1;
    checks++;
    if (result !== 32'h5EED_0001 || carry !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got %h, expected 5eed0001", result);
    end
    op = 4'd0;
    @(negedge clk);
    rst_n = 1'b1;

    run(4'd0, 0, 32'hFFFF_FFFF, 32'd1, 16'd0, "R1 add wrap");
    run(4'd0, 0, 32'h1234_0000, 32'h0000_5678, 16'd0, "R1 add");
    run(4'd1, 0, 32'd5, 32'd7, 16'd0, "R2 borrow");
    run(4'd1, 0, 32'd7, 32'd7, 16'd0, "R2 equal");
    run(4'd2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, "R3 mul");
    run(4'd3, 0, 32'h8000_0001, 32'hFFFF_FFE0, 16'd0, "R4 shr amt0");
    run(4'd4, 0, 32'h8000_0001, 32'h0000_003F, 16'd0, "R4 shl 31");
    run(4'd5, 0, 32'h0000_0001, 32'd1, 16'd0, "R5 ror");
    run(4'd6, 0, 32'h8000_0000, 32'hABC0_001F, 16'd0, "R5 rol 31");
    run(4'd7, 0, 32'hFFFF_FFFF, 32'd0, 16'd0, "R6 all ones");
    run(4'd7, 0, 32'h0000_0000, 32'd0, 16'd0, "R6 zero");
    run(4'd8, 0, 32'h0000_0000, 32'd0, 16'd0, "R7 all zero");
    run(4'd8, 0, 32'hF0F0_0001, 32'd0, 16'd0, "R7");
    run(4'd9, 0, 32'h5555_5555, 32'd0, 16'd0, "R8 alternating");
    run(4'd9, 0, 32'hFFFF_FFFF, 32'd0, 16'd0, "R8 flat");
    run(4'd9, 0, 32'h8000_0000, 32'd0, 16'd0, "R8 top edge");
    run(4'd0, 1, 32'h0000_0001, 32'hFFFF_FFFF, 16'hFFFF, "R9 imm zext");
    run(4'd1, 1, 32'd0, 32'd0, 16'h8000, "R9 imm sub");
    run(4'd10, 0, 32'd0, 32'd0, 16'd0, "R10 first");
    run(4'd10, 0, 32'd0, 32'd0, 16'd0, "R10 step");
    run(4'd0, 0, 32'd1, 32'd2, 16'd0, "R10 gap");
    run(4'd10, 0, 32'd0, 32'd0, 16'd0, "R10 after gap");
    run(4'd7, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, "R11 carry quiet");
    for (int o = 11; o < 16; o++) run(4'(o), 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, "R12 reserved");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] ro;
      ro = 4'($urandom_range(0, 15));
      run(ro, 1'($urandom()), $urandom(), $urandom(), 16'($urandom()), "rand R1-R12 mix");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule